// File: doc/BRIEF.md
# Precise Exception Commit Tracker

This block is the sideband that travels next to a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It does not touch operands or results. It carries a valid bit, the program counter and an exception tag for each instruction held in the four pipeline registers that follow fetch. A fault seen in a stage is written only into that instruction's tag. Nothing is acted on until the tagged instruction sits in writeback. At that point the block stores the instruction's PC and cause, squashes every younger instruction, and steers fetch to a fixed handler address on the next cycle.

An external interrupt request does not stop the pipeline directly. While the request is high, each advancing fetch slot is replaced by a marked no-op that carries the interrupt tag and the PC of the instruction it displaced. That no-op is then ordered like any other instruction. The request is assumed to stay high until software services it, so a no-op that is squashed by an older fault is injected again after the redirect. The datapath uses the retire and store-permit outputs to gate its register and memory writes, so a tagged instruction never changes architectural state.

Control is a two-state machine. `ST_RUN` is normal flow. The transition `RUN_TO_REDIRECT` fires when writeback holds a tagged instruction. The single cycle spent in `ST_REDIRECT` drives the redirect and blocks fetch entry. The transition `REDIRECT_TO_RUN` always fires after that one cycle.

Top module: `exc_precise_tracker`

## Requirements
- R1: After reset all four pipeline registers are empty, and take_o, kill_o, redirect_o, retire_o and mem_wr_ok_o are low, with epc_o and cause_o at zero.
- R2: With advance_i high, an instruction accepted at fetch moves one register per cycle and reaches writeback four advances later. If it is untagged, retire_o is high with retire_pc_o equal to its PC in that cycle. While advance_i is low every register holds.
- R3: A fault input is recorded against the instruction leaving its stage on an advancing cycle, with these cause codes: instruction TLB fault at fetch = 1, illegal instruction at decode = 2, overflow at execute = 3, data TLB fault at memory = 4. cause_o never exceeds 4.
- R4: An instruction that is already tagged keeps its first cause. A fault raised in a later stage does not replace it.
- R5: A tagged instruction raises take_o only in a cycle where it occupies writeback, whether advance_i is high or not. It never raises retire_o.
- R6: On a take, epc_o and cause_o load the writeback PC and cause at that clock edge and hold until the next take.
- R7: During a take cycle kill_o is 4'b1111 (bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory). All four pipeline registers are empty on the following cycle, so no younger instruction retires.
- R8: The cycle after a take has redirect_o high with redirect_pc_o equal to the VECTOR_PC parameter. It lasts one cycle, holds no take, and ignores the fetch inputs.
- R9: On an advancing cycle with irq_i high outside a redirect, the fetched instruction is replaced by a no-op tagged with cause 0 and the fetch PC. This wins over an instruction TLB fault in the same cycle.
- R10: An interrupt no-op squashed by an older exception is injected again after the redirect while irq_i stays high, and is then taken with cause 0.
- R11: mem_wr_ok_o is high exactly when the memory stage holds an untagged valid instruction, dtlb_fault_i is low, and no take happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| advance_i | input | 1 | Pipeline moves one stage this cycle |
| fetch_vld_i | input | 1 | Fetch stage holds a real instruction |
| fetch_pc_i | input | PC_W | PC of the instruction in fetch |
| itlb_fault_i | input | 1 | Instruction TLB fault for the fetch instruction |
| illegal_i | input | 1 | Decode found an illegal instruction |
| ovf_i | input | 1 | Execute produced an arithmetic overflow |
| dtlb_fault_i | input | 1 | Data TLB fault for the memory-stage instruction |
| irq_i | input | 1 | External interrupt request, level |
| take_o | output | 1 | Exception taken this cycle at writeback |
| kill_o | output | 4 | Squash for fetch, decode, execute, memory |
| redirect_o | output | 1 | Fetch must jump to redirect_pc_o |
| redirect_pc_o | output | PC_W | Handler address |
| epc_o | output | PC_W | Saved PC of the last taken exception |
| cause_o | output | 3 | Cause code of the last taken exception |
| retire_o | output | 1 | Writeback instruction may commit its register write |
| retire_pc_o | output | PC_W | PC of the retiring instruction |
| mem_wr_ok_o | output | 1 | Memory-stage store may be performed |

## Verification
The collision that matters most is a take at writeback in the same cycle that a younger untagged store sits in the memory stage. If the take did not veto the store, a younger instruction would change memory, and the exception would no longer be precise. A second collision is a take in a cycle where an interrupt no-op is being injected at fetch. The flush must win, and the interrupt must return after the redirect. Random bursts of interrupts are mixed with sparse faults at every stage and random stalls so that both collisions occur many times. Directed sequences force each one, and a cycle-level bench model of the requirements judges take, kill, store permit and the saved cause and PC in every cycle.

// File: rtl/exc_track_pkg.sv
package exc_track_pkg;

    localparam int CAUSE_W = 3;
    localparam int N_SLOT  = 4;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IRQ  = 3'd0,
        CAUSE_ITLB = 3'd1,
        CAUSE_ILL  = 3'd2,
        CAUSE_OVF  = 3'd3,
        CAUSE_DTLB = 3'd4
    } cause_e;

    typedef struct packed {
        logic   vld;
        logic   exc;
        cause_e cause;
    } tag_t;

    typedef enum logic [0:0] {
        ST_RUN      = 1'b0,
        ST_REDIRECT = 1'b1
    } trk_state_e;

    // Cause that belongs to the fault raised in stage idx (0 fetch .. 3 memory)
    function automatic cause_e stage_cause(int idx);
        cause_e c;
        case (idx)
            0:       c = CAUSE_ITLB;
            1:       c = CAUSE_ILL;
            2:       c = CAUSE_OVF;
            default: c = CAUSE_DTLB;
        endcase
        return c;
    endfunction

    // First fault wins: an already tagged entry is passed on unchanged
    function automatic tag_t tag_merge(tag_t t, logic fault, cause_e c);
        tag_t r;
        r = t;
        if (t.vld && !t.exc && fault) begin
            r.exc   = 1'b1;
            r.cause = c;
        end
        return r;
    endfunction

endpackage

// File: rtl/exc_stage_slot.sv
module exc_stage_slot
    import exc_track_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv_i,
    input  logic            flush_i,
    input  tag_t            in_tag_i,
    input  logic [PC_W-1:0] in_pc_i,
    output tag_t            tag_o,
    output logic [PC_W-1:0] pc_o
);

    tag_t            tag_q;
    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
            pc_q  <= '0;
        end else if (flush_i) begin
            tag_q <= '0;
        end else if (adv_i) begin
            tag_q <= in_tag_i;
            pc_q  <= in_pc_i;
        end
    end

    assign tag_o = tag_q;
    assign pc_o  = pc_q;

endmodule

// File: rtl/exc_fetch_gate.sv
module exc_fetch_gate
    import exc_track_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            fetch_vld_i,
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            irq_i,
    input  logic            block_i,
    output tag_t            ent_tag_o,
    output logic [PC_W-1:0] ent_pc_o
);

    always_comb begin
        ent_tag_o = '0;
        ent_pc_o  = fetch_pc_i;
        if (!block_i) begin
            if (irq_i) begin
                // marked no-op takes the place of the fetched instruction
                ent_tag_o.vld   = 1'b1;
                ent_tag_o.exc   = 1'b1;
                ent_tag_o.cause = CAUSE_IRQ;
            end else if (fetch_vld_i) begin
                ent_tag_o.vld   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/exc_commit_fsm.sv
module exc_commit_fsm
    import exc_track_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tag_t               wb_tag_i,
    input  logic [PC_W-1:0]    wb_pc_i,
    output logic               take_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o
);

    trk_state_e      state_q, state_d;
    logic            wb_tagged;
    logic [PC_W-1:0] epc_q;
    cause_e          cause_q;

    assign wb_tagged = wb_tag_i.vld && wb_tag_i.exc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (wb_tagged) state_d = ST_REDIRECT;
            ST_REDIRECT: state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    always_comb begin
        take_o     = 1'b0;
        redirect_o = 1'b0;
        unique case (state_q)
            ST_RUN:      take_o     = wb_tagged;
            ST_REDIRECT: redirect_o = 1'b1;
            default:     take_o     = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= CAUSE_IRQ;
        end else if (take_o) begin
            epc_q   <= wb_pc_i;
            cause_q <= wb_tag_i.cause;
        end
    end

    assign epc_o   = epc_q;
    assign cause_o = cause_q;

endmodule

// File: rtl/exc_precise_tracker.sv
module exc_precise_tracker
    import exc_track_pkg::*;
#(
    parameter int              PC_W      = 32,
    parameter logic [PC_W-1:0] VECTOR_PC = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance_i,
    input  logic               fetch_vld_i,
    input  logic [PC_W-1:0]    fetch_pc_i,
    input  logic               itlb_fault_i,
    input  logic               illegal_i,
    input  logic               ovf_i,
    input  logic               dtlb_fault_i,
    input  logic               irq_i,
    output logic               take_o,
    output logic [N_SLOT-1:0]  kill_o,
    output logic               redirect_o,
    output logic [PC_W-1:0]    redirect_pc_o,
    output logic [PC_W-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               retire_o,
    output logic [PC_W-1:0]    retire_pc_o,
    output logic               mem_wr_ok_o
);

    localparam int WB  = N_SLOT - 1;
    localparam int MEM = N_SLOT - 2;

    logic [N_SLOT-1:0] fault_vec;
    tag_t              ent_tag;
    logic [PC_W-1:0]   ent_pc;
    tag_t              st_in  [N_SLOT];
    logic [PC_W-1:0]   pc_in  [N_SLOT];
    tag_t              st_tag [N_SLOT];
    logic [PC_W-1:0]   st_pc  [N_SLOT];
    logic              take_w;
    logic              redir_w;

    // fault raised while an instruction is in stage k, k = 0 fetch .. 3 memory
    assign fault_vec = {dtlb_fault_i, ovf_i, illegal_i, itlb_fault_i};

    exc_fetch_gate #(.PC_W(PC_W)) u_gate (
        .fetch_vld_i (fetch_vld_i),
        .fetch_pc_i  (fetch_pc_i),
        .irq_i       (irq_i),
        .block_i     (redir_w),
        .ent_tag_o   (ent_tag),
        .ent_pc_o    (ent_pc)
    );

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        if (g == 0) begin : g_head
            assign st_in[g] = tag_merge(ent_tag, fault_vec[g], stage_cause(g));
            assign pc_in[g] = ent_pc;
        end else begin : g_body
            assign st_in[g] = tag_merge(st_tag[g-1], fault_vec[g], stage_cause(g));
            assign pc_in[g] = st_pc[g-1];
        end

        exc_stage_slot #(.PC_W(PC_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv_i    (advance_i),
            .flush_i  (take_w),
            .in_tag_i (st_in[g]),
            .in_pc_i  (pc_in[g]),
            .tag_o    (st_tag[g]),
            .pc_o     (st_pc[g])
        );
    end

    exc_commit_fsm #(.PC_W(PC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wb_tag_i   (st_tag[WB]),
        .wb_pc_i    (st_pc[WB]),
        .take_o     (take_w),
        .redirect_o (redir_w),
        .epc_o      (epc_o),
        .cause_o    (cause_o)
    );

    assign take_o        = take_w;
    assign kill_o        = {N_SLOT{take_w}};
    assign redirect_o    = redir_w;
    assign redirect_pc_o = VECTOR_PC;
    assign retire_o      = st_tag[WB].vld && !st_tag[WB].exc;
    assign retire_pc_o   = st_pc[WB];
    assign mem_wr_ok_o   = st_tag[MEM].vld && !st_tag[MEM].exc && !dtlb_fault_i && !take_w;

endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_o,
    input logic [3:0]      kill_o,
    input logic            redirect_o,
    input logic [PC_W-1:0] epc_o,
    input logic [2:0]      cause_o,
    input logic            retire_o,
    input logic            mem_wr_ok_o
);

    assert_kill_on_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> kill_o == 4'b1111);

    assert_kill_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> kill_o == 4'b0000);

    assert_redirect_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> redirect_o);

    assert_redirect_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    assert_no_take_in_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> !take_o);

    assert_epc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |=> ($stable(epc_o) && $stable(cause_o)));

    assert_take_not_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_o && retire_o));

    assert_store_veto_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !mem_wr_ok_o);

    assert_cause_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o <= 3'd4);

endmodule

bind exc_precise_tracker exc_tracker_chk #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_o      (take_o),
    .kill_o      (kill_o),
    .redirect_o  (redirect_o),
    .epc_o       (epc_o),
    .cause_o     (cause_o),
    .retire_o    (retire_o),
    .mem_wr_ok_o (mem_wr_ok_o)
);

// File: tb/exc_precise_tracker_tb.sv
module exc_precise_tracker_tb;

    localparam int          PC_W = 32;
    localparam logic [31:0] VEC  = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance_i = 1'b0, fetch_vld_i = 1'b0;
    logic [31:0] fetch_pc_i = '0;
    logic        itlb_fault_i = 1'b0, illegal_i = 1'b0, ovf_i = 1'b0;
    logic        dtlb_fault_i = 1'b0, irq_i = 1'b0;
    logic        take_o, redirect_o, retire_o, mem_wr_ok_o;
    logic [3:0]  kill_o;
    logic [31:0] redirect_pc_o, epc_o, retire_pc_o;
    logic [2:0]  cause_o;

    exc_precise_tracker #(.PC_W(PC_W), .VECTOR_PC(VEC)) u_dut (
        .clk(clk), .rst_n(rst_n), .advance_i(advance_i), .fetch_vld_i(fetch_vld_i),
        .fetch_pc_i(fetch_pc_i), .itlb_fault_i(itlb_fault_i), .illegal_i(illegal_i),
        .ovf_i(ovf_i), .dtlb_fault_i(dtlb_fault_i), .irq_i(irq_i), .take_o(take_o),
        .kill_o(kill_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .epc_o(epc_o), .cause_o(cause_o), .retire_o(retire_o),
        .retire_pc_o(retire_pc_o), .mem_wr_ok_o(mem_wr_ok_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model of the four pipeline registers and the commit state
    bit          mv [4];
    bit          me [4];
    int          mc [4];
    logic [31:0] mp [4];
    bit          m_red = 1'b0;
    logic [31:0] m_epc = '0;
    int          m_cause = 0;
    logic [31:0] pc_ctr = 32'h0000_1000;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_take_f();
        return !m_red && mv[3] && me[3];
    endfunction

    task automatic cycle(input bit adv, input bit fv, input bit f_itlb, input bit f_ill,
                         input bit f_ovf, input bit f_dtlb, input bit f_irq);
        bit t;
        bit flt [4];
        @(negedge clk);
        advance_i = adv; fetch_vld_i = fv; fetch_pc_i = pc_ctr;
        itlb_fault_i = f_itlb; illegal_i = f_ill; ovf_i = f_ovf;
        dtlb_fault_i = f_dtlb; irq_i = f_irq;
        #1;
        t = exp_take_f();
        chk("R5", "take", {31'd0, take_o}, {31'd0, t});
        chk("R7", "kill", {28'd0, kill_o}, t ? 32'hF : 32'h0);
        chk("R8", "redirect", {31'd0, redirect_o}, {31'd0, m_red});
        chk("R8", "redirect_pc", redirect_pc_o, VEC);
        chk("R2", "retire", {31'd0, retire_o}, {31'd0, mv[3] && !me[3]});
        if (mv[3] && !me[3]) chk("R2", "retire_pc", retire_pc_o, mp[3]);
        chk("R11", "mem_wr_ok", {31'd0, mem_wr_ok_o}, {31'd0, mv[2] && !me[2] && !f_dtlb && !t});
        chk("R6", "epc", epc_o, m_epc);
        chk("R6", "cause", {29'd0, cause_o}, m_cause);
        flt[0] = f_itlb; flt[1] = f_ill; flt[2] = f_ovf; flt[3] = f_dtlb;
        if (t) begin
            m_epc = mp[3]; m_cause = mc[3];
            for (int k = 0; k < 4; k++) mv[k] = 1'b0;
            m_red = 1'b1;
        end else begin
            if (adv) begin
                for (int k = 3; k >= 1; k--) begin
                    mv[k] = mv[k-1]; me[k] = me[k-1]; mc[k] = mc[k-1]; mp[k] = mp[k-1];
                    if (mv[k] && !me[k] && flt[k]) begin me[k] = 1'b1; mc[k] = k + 1; end
                end
                mp[0] = pc_ctr;
                if (m_red)      begin mv[0] = 1'b0; me[0] = 1'b0; end
                else if (f_irq) begin mv[0] = 1'b1; me[0] = 1'b1; mc[0] = 0; end
                else if (fv)    begin mv[0] = 1'b1; me[0] = f_itlb; mc[0] = f_itlb ? 1 : 0; end
                else            begin mv[0] = 1'b0; me[0] = 1'b0; end
            end
            m_red = 1'b0;
        end
        pc_ctr = m_red ? VEC : pc_ctr + 32'd4;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] p0;
        int irq_left;
        void'($urandom(32'd7321));
        for (int k = 0; k < 4; k++) begin mv[k] = 0; me[k] = 0; mc[k] = 0; mp[k] = '0; end
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "take", {31'd0, take_o}, 0);
        chk("R1", "kill", {28'd0, kill_o}, 0);
        chk("R1", "redirect", {31'd0, redirect_o}, 0);
        chk("R1", "retire", {31'd0, retire_o}, 0);
        chk("R1", "mem_wr_ok", {31'd0, mem_wr_ok_o}, 0);
        chk("R1", "epc", epc_o, 0);
        chk("R1", "cause", {29'd0, cause_o}, 0);
        rst_n = 1'b1;

        // R2: two clean instructions, one stall in the middle
        cycle(1, 1, 0, 0, 0, 0, 0);
        cycle(1, 1, 0, 0, 0, 0, 0);
        cycle(0, 1, 0, 0, 0, 0, 0);
        idle(6);

        // R3 / R4: illegal at decode, then overflow at execute; first cause kept
        p0 = pc_ctr;
        cycle(1, 1, 0, 0, 0, 0, 0);
        cycle(1, 1, 0, 1, 0, 0, 0);
        cycle(1, 1, 0, 0, 1, 0, 0);
        cycle(1, 1, 0, 0, 0, 0, 0);
        cycle(1, 1, 0, 0, 0, 0, 0);
        cycle(1, 1, 0, 0, 0, 0, 0);
        chk("R4", "first cause kept", {29'd0, cause_o}, 32'd2);
        chk("R6", "saved pc", epc_o, p0);
        idle(5);

        // R3 / R5 / R11: data TLB fault in memory, take while stalled in writeback
        p0 = pc_ctr;
        cycle(1, 1, 0, 0, 0, 0, 0);
        cycle(1, 0, 0, 0, 0, 0, 0);
        cycle(1, 0, 0, 0, 0, 0, 0);
        cycle(1, 0, 0, 0, 0, 1, 0);
        cycle(0, 0, 0, 0, 0, 0, 0);
        cycle(0, 0, 0, 0, 0, 0, 0);
        chk("R3", "dtlb cause", {29'd0, cause_o}, 32'd4);
        chk("R5", "stalled take pc", epc_o, p0);
        idle(5);

        // R9: interrupt beats an instruction TLB fault in the same fetch slot
        p0 = pc_ctr;
        cycle(1, 1, 1, 0, 0, 0, 1);
        idle(5);
        chk("R9", "irq wins", {29'd0, cause_o}, 32'd0);
        chk("R9", "irq pc", epc_o, p0);
        idle(3);

        // R10: older overflow flushes the interrupt no-op, which returns later
        p0 = pc_ctr;
        cycle(1, 1, 0, 0, 0, 0, 0);
        cycle(1, 1, 0, 0, 0, 0, 1);
        cycle(1, 1, 0, 0, 1, 0, 1);
        cycle(1, 1, 0, 0, 0, 0, 1);
        cycle(1, 1, 0, 0, 0, 0, 1);
        cycle(1, 1, 0, 0, 0, 0, 1);
        chk("R10", "older fault first", {29'd0, cause_o}, 32'd3);
        chk("R10", "older pc", epc_o, p0);
        for (int i = 0; i < 6; i++) cycle(1, 1, 0, 0, 0, 0, 1);
        chk("R10", "reinjected irq", {29'd0, cause_o}, 32'd0);
        idle(5);

        // random mix
        irq_left = 0;
        for (int i = 0; i < 4000; i++) begin
            bit r_irq;
            if (irq_left > 0) irq_left--;
            else if ($urandom_range(0, 99) < 2) irq_left = $urandom_range(3, 20);
            r_irq = (irq_left > 0);
            cycle($urandom_range(0, 99) < 80, $urandom_range(0, 99) < 85,
                  $urandom_range(0, 99) < 4, $urandom_range(0, 99) < 4,
                  $urandom_range(0, 99) < 4, $urandom_range(0, 99) < 4, r_irq);
        end
        idle(8);
        finish_run();
    end

endmodule